// File: doc/BRIEF.md
# Display Host Bus Register File

This block sits between an 8-bit host bus and the refresh logic of an eight-digit dot-matrix display. The host drives an active-low chip enable, active-low write and read strobes, an active-low flash select and five address lines. The block decodes these into five storage regions and performs single-byte reads and writes on them:

- the character bytes, one per digit;
- one flash attribute bit per digit;
- a 4-bit pointer that selects a user-defined glyph;
- the dot rows of sixteen user-defined glyphs;
- a control word holding brightness, flash enable, blink enable, self-test start and clear.

The stored contents go straight out to the refresh and decode logic. A side port lets that logic fetch any row of any user glyph.

A host clear command fills the character bytes with the space code and empties the flash bits. The fill runs over a fixed number of clocks, and the clear bit drops by itself when the fill ends. An external reset blanks the character bytes and zeroes the flash bits and the control word, then holds the block busy for the same fill window. User glyphs and the glyph pointer survive both the clear and the reset. Host writes that arrive while a fill is running are dropped.

Top module: `dispHostBus`

## Requirements
- R1: With `flashSelN` low, the flash bit of digit `addr[2:0]` is accessed whatever `addr[4:3]` holds. A write stores `wrData[0]`. A read returns that bit in bit 0 and zeros above it. `flashMask[d]` is the bit of digit d.
- R2: With `flashSelN` high, `addr[4:3]` selects the region: 00 the glyph pointer, 01 the glyph rows, 10 the control word, 11 the character bytes. The pointer stores `wrData[3:0]` and reads back zero-extended.
- R3: A write takes effect once, on the first clock edge that sees `ceN` and `wrN` low with `rdN` high. Further write strobes inside the same `ceN`-low period are ignored until `ceN` has been high at a clock edge.
- R4: An access with `wrN` and `rdN` both low neither writes nor reads. `rdData` is zero whenever no read is in progress.
- R5: Character bytes store and read back all eight bits. Digit d appears on `charCodes[8*d+7:8*d]`, and `addr[2:0]`=000 is digit 0. Bit 7 = 0 marks an ASCII code in bits 6..0. Bit 7 = 1 marks a glyph index in bits 3..0.
- R6: A glyph-row write stores `wrData[4:0]` (bit 4 is the leftmost column) into row `addr[2:0]` of the glyph the pointer selects. Rows 0 to 6 exist. Writes to row 7 are ignored, and reading row 7 returns zero. `refDots` returns row `refRow` of glyph `refIdx` in the same cycle.
- R7: Control word fields: bits 2..0 brightness, bit 3 flash enable, bit 4 blink enable, bit 6 self-test start, bit 7 clear. Each write updates all of them together, and they drive `brightness`, `flashEnable`, `blinkEnable` and `selfTestStart`.
- R8: Control bit 5 cannot be written. A control read returns the `selfTestPass` input in bit 5.
- R9: Writing the control word with bit 7 set starts a clear. From the next edge on, every character byte reads 20h and every flash bit reads 0. Bit 7 reads 1 until the fill ends and 0 afterwards. The glyph rows, the pointer and the other control bits are left as they were.
- R10: `fillBusy` is high for exactly 3 clock edges after the edge that accepted a clear, and for exactly 3 edges after reset is released. Host writes are dropped while it is high.
- R11: Reset (`rstN` low) sets every character byte to 20h and zeroes the flash bits and the control word. The glyph rows and the pointer keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| flashSelN | input | 1 | Low selects the flash attribute bits |
| addr | input | 5 | Bits 4..3 pick the region, bits 2..0 the digit or row |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data, zero when no read is in progress |
| selfTestPass | input | 1 | Result from the self-test engine, read as control bit 5 |
| refIdx | input | 4 | Glyph index for the refresh fetch |
| refRow | input | 3 | Glyph row for the refresh fetch |
| refDots | output | 5 | Dots of the fetched glyph row, bit 4 leftmost |
| charCodes | output | 64 | All character bytes, digit 0 in the low byte |
| flashMask | output | 8 | Flash attribute bit per digit |
| brightness | output | 3 | Brightness code |
| flashEnable | output | 1 | Flash attribute enable |
| blinkEnable | output | 1 | Whole-display blink enable |
| selfTestStart | output | 1 | Self-test start request |
| fillBusy | output | 1 | Clear or reset fill in progress |

## Verification
Every stored bit either drives an export or can be read back, so a wrong internal value shows at the ports right away. A misdecoded region or a lost write shows on the next read or on `charCodes`/`flashMask` one edge after the write. A write that fired twice inside one chip-enable period shows as the second data byte in storage. A fill counter that is off by one shows as `fillBusy` falling one edge early or late. It also shows as a host write landing, or being dropped, on the boundary edge. A clear that touches the wrong storage shows as changed glyph rows or a changed pointer once `fillBusy` falls.

// File: rtl/dispHostPkg.sv
package dispHostPkg;

  localparam logic [7:0] BLANK_CODE = 8'h20;

  typedef enum logic [2:0] {
    REG_FLASH,
    REG_UDCADDR,
    REG_UDCROW,
    REG_CTRL,
    REG_CHAR
  } regionT;

  // strobes from the control half to the storage half
  typedef struct packed {
    logic wrFlash;
    logic wrUdcAddr;
    logic wrUdcRow;
    logic wrCtrl;
    logic wrChar;
    logic fill;     // blank the character bytes and flash bits this edge
    logic fillEnd;  // last fill edge: drop the clear bit
  } strobeT;

  function automatic regionT decodeRegion(input logic flashSelN, input logic [1:0] hi);
    if (!flashSelN) return REG_FLASH;
    case (hi)
      2'b00:   return REG_UDCADDR;
      2'b01:   return REG_UDCROW;
      2'b10:   return REG_CTRL;
      default: return REG_CHAR;
    endcase
  endfunction

endpackage

// File: rtl/dispHostCtrl.sv
module dispHostCtrl
  import dispHostPkg::*;
#(
  parameter int FILL_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       wrN,
  input  logic       rdN,
  input  logic       flashSelN,
  input  logic [1:0] addrHi,
  input  logic       clrReq,
  output strobeT     strobe,
  output logic       busy
);

  localparam int CNT_W = $clog2(FILL_CYCLES + 1);
  localparam logic [CNT_W-1:0] FILL_LOAD = CNT_W'(FILL_CYCLES);

  logic [CNT_W-1:0] fillCnt;
  logic             armed;
  logic             wrFire;
  regionT           region;

  assign region = decodeRegion(flashSelN, addrHi);
  assign busy   = (fillCnt != '0);
  // R3/R4: one write per chip-enable period, only with a lone write strobe
  assign wrFire = !ceN && !wrN && rdN && armed && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= FILL_LOAD;   // R11: reset also runs the fill window
      armed   <= 1'b1;
    end else begin
      if (ceN)       armed <= 1'b1;
      else if (!wrN) armed <= 1'b0;
      if (busy)
        fillCnt <= fillCnt - 1'b1;
      else if (wrFire && region == REG_CTRL && clrReq)
        fillCnt <= FILL_LOAD;  // R9: clear command
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.fill    = busy;
    strobe.fillEnd = (fillCnt == CNT_W'(1));
    if (wrFire) begin
      case (region)
        REG_FLASH:   strobe.wrFlash   = 1'b1;
        REG_UDCADDR: strobe.wrUdcAddr = 1'b1;
        REG_UDCROW:  strobe.wrUdcRow  = 1'b1;
        REG_CTRL:    strobe.wrCtrl    = 1'b1;
        default:     strobe.wrChar    = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dispHostData.sv
module dispHostData
  import dispHostPkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int UDC_COUNT  = 16,
  parameter int UDC_ROWS   = 7,
  parameter int DOT_COLS   = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobeT                      strobe,
  input  logic                        flashSelN,
  input  logic [1:0]                  addrHi,
  input  logic [2:0]                  addrLo,
  input  logic [7:0]                  wrData,
  input  logic                        rdEn,
  input  logic                        selfTestPass,
  input  logic [$clog2(UDC_COUNT)-1:0] refIdx,
  input  logic [2:0]                  refRow,
  output logic [DOT_COLS-1:0]         refDots,
  output logic [7:0]                  rdData,
  output logic [NUM_DIGITS*8-1:0]     charCodes,
  output logic [NUM_DIGITS-1:0]       flashMask,
  output logic [2:0]                  brightness,
  output logic                        flashEnable,
  output logic                        blinkEnable,
  output logic                        selfTestStart
);

  localparam int IDX_W  = $clog2(UDC_COUNT);
  localparam int SLOTS  = UDC_COUNT * UDC_ROWS;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [2:0] ROW_LIMIT = 3'(UDC_ROWS);

  logic [7:0]          charMem [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] flashBits;
  logic [IDX_W-1:0]    udcAddr;
  logic [DOT_COLS-1:0] udcMem [SLOTS];
  logic [2:0]          bright;
  logic                fEn, bEn, stStart, clrBit;
  logic [SLOT_W-1:0]   busSlot, refSlot;

  assign busSlot = SLOT_W'(udcAddr) * SLOT_W'(UDC_ROWS) + SLOT_W'(addrLo);
  assign refSlot = SLOT_W'(refIdx) * SLOT_W'(UDC_ROWS) + SLOT_W'(refRow);

  // R5/R1/R7/R9/R11: resettable storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DIGITS; i++) charMem[i] <= BLANK_CODE;
      flashBits <= '0;
      bright    <= '0;
      fEn       <= 1'b0;
      bEn       <= 1'b0;
      stStart   <= 1'b0;
      clrBit    <= 1'b0;
    end else begin
      if (strobe.fill) begin
        for (int i = 0; i < NUM_DIGITS; i++) charMem[i] <= BLANK_CODE;
        flashBits <= '0;
      end else begin
        if (strobe.wrChar)  charMem[addrLo]   <= wrData;
        if (strobe.wrFlash) flashBits[addrLo] <= wrData[0];
      end
      if (strobe.wrCtrl) begin
        {clrBit, stStart} <= wrData[7:6];   // R8: bit 5 not stored
        bEn    <= wrData[4];
        fEn    <= wrData[3];
        bright <= wrData[2:0];
      end else if (strobe.fillEnd) begin
        clrBit <= 1'b0;
      end
    end
  end

  // R6/R11: glyph storage, untouched by reset and clear
  always_ff @(posedge clk) begin
    if (strobe.wrUdcAddr) udcAddr <= wrData[IDX_W-1:0];
    if (strobe.wrUdcRow && addrLo < ROW_LIMIT) udcMem[busSlot] <= wrData[DOT_COLS-1:0];
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (decodeRegion(flashSelN, addrHi))
        REG_FLASH:   rdData[0] = flashBits[addrLo];
        REG_UDCADDR: rdData[IDX_W-1:0] = udcAddr;
        REG_UDCROW:  if (addrLo < ROW_LIMIT) rdData[DOT_COLS-1:0] = udcMem[busSlot];
        REG_CTRL:    rdData = {clrBit, stStart, selfTestPass, bEn, fEn, bright};
        default:     rdData = charMem[addrLo];
      endcase
    end
  end

  assign refDots = (refRow < ROW_LIMIT) ? udcMem[refSlot] : '0;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gExport
    assign charCodes[g*8 +: 8] = charMem[g];
  end

  assign flashMask     = flashBits;
  assign brightness    = bright;
  assign flashEnable   = fEn;
  assign blinkEnable   = bEn;
  assign selfTestStart = stStart;

endmodule

// File: rtl/dispHostBus.sv
module dispHostBus
  import dispHostPkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int UDC_COUNT   = 16,
  parameter int UDC_ROWS    = 7,
  parameter int DOT_COLS    = 5,
  parameter int FILL_CYCLES = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ceN,
  input  logic                          wrN,
  input  logic                          rdN,
  input  logic                          flashSelN,
  input  logic [4:0]                    addr,
  input  logic [7:0]                    wrData,
  output logic [7:0]                    rdData,
  input  logic                          selfTestPass,
  input  logic [$clog2(UDC_COUNT)-1:0]  refIdx,
  input  logic [2:0]                    refRow,
  output logic [DOT_COLS-1:0]           refDots,
  output logic [NUM_DIGITS*8-1:0]       charCodes,
  output logic [NUM_DIGITS-1:0]         flashMask,
  output logic [2:0]                    brightness,
  output logic                          flashEnable,
  output logic                          blinkEnable,
  output logic                          selfTestStart,
  output logic                          fillBusy
);

  strobeT strobe;
  logic   rdEn;

  assign rdEn = !ceN && !rdN && wrN;

  dispHostCtrl #(.FILL_CYCLES(FILL_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .wrN(wrN), .rdN(rdN),
    .flashSelN(flashSelN), .addrHi(addr[4:3]), .clrReq(wrData[7]),
    .strobe(strobe), .busy(fillBusy)
  );

  dispHostData #(
    .NUM_DIGITS(NUM_DIGITS), .UDC_COUNT(UDC_COUNT),
    .UDC_ROWS(UDC_ROWS), .DOT_COLS(DOT_COLS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flashSelN(flashSelN),
    .addrHi(addr[4:3]), .addrLo(addr[2:0]), .wrData(wrData), .rdEn(rdEn),
    .selfTestPass(selfTestPass), .refIdx(refIdx), .refRow(refRow),
    .refDots(refDots), .rdData(rdData), .charCodes(charCodes),
    .flashMask(flashMask), .brightness(brightness), .flashEnable(flashEnable),
    .blinkEnable(blinkEnable), .selfTestStart(selfTestStart)
  );

endmodule

// File: rtl/dispHostBusChk.sv
module dispHostBusChk #(
  parameter int NUM_DIGITS  = 8,
  parameter int FILL_CYCLES = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    ceN,
  input logic                    wrN,
  input logic                    rdN,
  input logic                    flashSelN,
  input logic [1:0]              addrHi,
  input logic [7:0]              rdData,
  input logic                    selfTestPass,
  input logic [NUM_DIGITS*8-1:0] charCodes,
  input logic [NUM_DIGITS-1:0]   flashMask,
  input logic [2:0]              brightness,
  input logic                    flashEnable,
  input logic                    blinkEnable,
  input logic                    selfTestStart,
  input logic                    fillBusy
);

  localparam logic [7:0] RUN_LIMIT = 8'(FILL_CYCLES);

  logic [7:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= fillBusy ? busyRun + 8'd1 : 8'd0;
  end

  a_r10_fill_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_LIMIT);

  a_r9_fill_blanks: assert property (@(posedge clk) disable iff (!rstN)
    fillBusy |=> (charCodes == {NUM_DIGITS{8'h20}}) && (flashMask == '0));

  a_r7_ctrl_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ceN && !fillBusy) |=> $stable(brightness) && $stable(flashEnable)
                           && $stable(blinkEnable) && $stable(selfTestStart));

  a_r5_store_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ceN && !fillBusy) |=> $stable(charCodes) && $stable(flashMask));

  a_r4_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || rdN || !wrN) |-> (rdData == 8'h00));

  a_r8_status_bit: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !rdN && wrN && flashSelN && addrHi == 2'b10) |-> (rdData[5] == selfTestPass));

endmodule

bind dispHostBus dispHostBusChk #(.NUM_DIGITS(NUM_DIGITS), .FILL_CYCLES(FILL_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .wrN(wrN), .rdN(rdN), .flashSelN(flashSelN),
  .addrHi(addr[4:3]), .rdData(rdData), .selfTestPass(selfTestPass),
  .charCodes(charCodes), .flashMask(flashMask), .brightness(brightness),
  .flashEnable(flashEnable), .blinkEnable(blinkEnable),
  .selfTestStart(selfTestStart), .fillBusy(fillBusy)
);

// File: tb/dispHostBus_test.sv
module dispHostBus_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b1, wrN = 1'b1, rdN = 1'b1, flashSelN = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       selfTestPass = 1'b0;
  logic [3:0] refIdx = '0;
  logic [2:0] refRow = '0;
  logic [7:0] rdData;
  logic [4:0] refDots;
  logic [63:0] charCodes;
  logic [7:0] flashMask;
  logic [2:0] brightness;
  logic       flashEnable, blinkEnable, selfTestStart, fillBusy;

  int  checks = 0;
  int  bad = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispHostBus uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .wrN(wrN), .rdN(rdN), .flashSelN(flashSelN),
    .addr(addr), .wrData(wrData), .rdData(rdData), .selfTestPass(selfTestPass),
    .refIdx(refIdx), .refRow(refRow), .refDots(refDots), .charCodes(charCodes),
    .flashMask(flashMask), .brightness(brightness), .flashEnable(flashEnable),
    .blinkEnable(blinkEnable), .selfTestStart(selfTestStart), .fillBusy(fillBusy)
  );

  localparam logic [4:0] A_UADDR = 5'b00_000;
  localparam logic [4:0] A_CTRL  = 5'b10_000;
  function automatic logic [4:0] aChar(input int d); return {2'b11, 3'(d)}; endfunction
  function automatic logic [4:0] aRow(input int r);  return {2'b01, 3'(r)}; endfunction
  localparam logic [63:0] ALL_BLANK = {8{8'h20}};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic fsN, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    flashSelN = fsN; addr = a; wrData = d; ceN = 0; wrN = 0;
    @(negedge clk);
    wrN = 1; ceN = 1;
  endtask

  task automatic busRead(input logic fsN, input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    flashSelN = fsN; addr = a; ceN = 0; rdN = 0;
    #1 d = rdData;
    rdN = 1; ceN = 1; flashSelN = 1;
  endtask

  task automatic testReset;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    addr = aChar(0); wrData = 8'h41; ceN = 0; wrN = 0;   // write during reset fill
    #1 check("R10 busy at reset release", 64'(fillBusy), 64'd1);
    @(negedge clk); wrN = 1; ceN = 1;
    check("R10 busy after edge 1", 64'(fillBusy), 64'd1);
    @(negedge clk);
    check("R10 busy after edge 2", 64'(fillBusy), 64'd1);
    @(negedge clk);
    check("R10 idle after edge 3", 64'(fillBusy), 64'd0);
    check("R11 chars blank", charCodes, ALL_BLANK);
    busRead(1, aChar(0), v); check("R10 write during fill dropped", 64'(v), 64'h20);
    busRead(1, A_CTRL, v);   check("R11 control zero", 64'(v), 64'h00);
    check("R11 flash zero", 64'(flashMask), 64'h00);
  endtask

  task automatic testChars;
    logic [7:0] v;
    busWrite(1, aChar(3), 8'h41);
    busWrite(1, aChar(7), 8'h85);
    busRead(1, aChar(3), v); check("R5 read digit 3", 64'(v), 64'h41);
    busRead(1, aChar(7), v); check("R5 read digit 7 glyph code", 64'(v), 64'h85);
    check("R5 export digit 3", 64'(charCodes[31:24]), 64'h41);
    check("R5 export digit 7", 64'(charCodes[63:56]), 64'h85);
  endtask

  task automatic testFlash;
    logic [7:0] v;
    busWrite(0, 5'b01_010, 8'hFF);
    busRead(0, 5'b10_010, v); check("R1 flash read ignores A4A3", 64'(v), 64'h01);
    check("R1 flash mask", 64'(flashMask), 64'h04);
    busRead(1, aChar(2), v); check("R2 flash write left char alone", 64'(v), 64'h20);
    busWrite(0, 5'b00_010, 8'hFE);
    check("R1 flash cleared by D0=0", 64'(flashMask), 64'h00);
  endtask

  task automatic testUdc;
    logic [7:0] v;
    busWrite(1, A_UADDR, 8'hA5);
    busRead(1, A_UADDR, v); check("R2 pointer zero-extended", 64'(v), 64'h05);
    busWrite(1, aRow(0), 8'hFF);
    busWrite(1, aRow(6), 8'h10);
    busWrite(1, aRow(7), 8'h1F);
    busRead(1, aRow(0), v); check("R6 row 0 five bits", 64'(v), 64'h1F);
    busRead(1, aRow(6), v); check("R6 row 6", 64'(v), 64'h10);
    busRead(1, aRow(7), v); check("R6 row 7 reads zero", 64'(v), 64'h00);
    busWrite(1, A_UADDR, 8'h03);
    busWrite(1, aRow(0), 8'h0A);
    @(negedge clk); refIdx = 4'd5; refRow = 3'd0;
    #1 check("R6 refresh fetch glyph 5", 64'(refDots), 64'h1F);
    refIdx = 4'd3;
    #1 check("R6 refresh fetch glyph 3", 64'(refDots), 64'h0A);
    refRow = 3'd7;
    #1 check("R6 refresh row 7 zero", 64'(refDots), 64'h00);
    busRead(1, aRow(0), v); check("R6 bus row via pointer", 64'(v), 64'h0A);
  endtask

  task automatic testControl;
    logic [7:0] v;
    selfTestPass = 1;
    busWrite(1, A_CTRL, 8'h5B);
    busRead(1, A_CTRL, v); check("R8 status bit from input", 64'(v), 64'h7B);
    check("R7 brightness", 64'(brightness), 64'd3);
    check("R7 enables", 64'({flashEnable, blinkEnable, selfTestStart}), 64'b111);
    selfTestPass = 0;
    busWrite(1, A_CTRL, 8'h20);
    busRead(1, A_CTRL, v); check("R8 bit 5 not writable", 64'(v), 64'h00);
    check("R7 all fields replaced", 64'({brightness, flashEnable, blinkEnable, selfTestStart}), 64'd0);
  endtask

  task automatic testStrobes;
    logic [7:0] v;
    @(negedge clk); addr = aChar(1); wrData = 8'h31; ceN = 0; wrN = 0;
    @(negedge clk); wrN = 1; wrData = 8'h32;
    @(negedge clk); wrN = 0;
    @(negedge clk); wrN = 1; ceN = 1;
    busRead(1, aChar(1), v); check("R3 one write per CE period", 64'(v), 64'h31);
    @(negedge clk); wrData = 8'h33; ceN = 0; wrN = 0; rdN = 0;
    #1 check("R4 no read with both strobes", 64'(rdData), 64'h00);
    @(negedge clk); wrN = 1; rdN = 1; ceN = 1;
    busRead(1, aChar(1), v); check("R4 no write with both strobes", 64'(v), 64'h31);
    @(negedge clk); rdN = 0;
    #1 check("R4 read without CE is zero", 64'(rdData), 64'h00);
    rdN = 1;
  endtask

  task automatic testClear;
    logic [7:0] v;
    busWrite(0, 5'b00_110, 8'h01);
    busWrite(1, A_CTRL, 8'h8A);          // accepted at edge E0
    check("R10 busy after clear", 64'(fillBusy), 64'd1);
    rdN = 0; ceN = 0; addr = A_CTRL;
    #1 check("R9 clear bit reads 1", 64'(rdData), 64'h8A);
    rdN = 1; addr = aChar(0); wrData = 8'h55; wrN = 0;   // write lands on E1
    @(negedge clk); wrN = 1; ceN = 1;
    check("R9 chars blank", charCodes, ALL_BLANK);
    check("R9 flash empty", 64'(flashMask), 64'h00);
    check("R10 busy edge 1", 64'(fillBusy), 64'd1);
    @(negedge clk); check("R10 busy edge 2", 64'(fillBusy), 64'd1);
    @(negedge clk); check("R10 idle edge 3", 64'(fillBusy), 64'd0);
    busRead(1, A_CTRL, v);  check("R9 clear bit dropped, rest kept", 64'(v), 64'h0A);
    busRead(1, aChar(0), v); check("R10 write during clear dropped", 64'(v), 64'h20);
    busRead(1, A_UADDR, v); check("R9 pointer kept", 64'(v), 64'h03);
    busRead(1, aRow(0), v); check("R9 glyph row kept", 64'(v), 64'h0A);
    busWrite(1, aChar(0), 8'h56);
    busRead(1, aChar(0), v); check("R10 writes resume", 64'(v), 64'h56);
  endtask

  task automatic testResetKeeps;
    logic [7:0] v;
    busWrite(0, 5'b00_001, 8'h01);
    @(negedge clk); rstN = 0;
    #1 check("R11 chars blank in reset", charCodes, ALL_BLANK);
    check("R11 control zero in reset", 64'({brightness, flashEnable}), 64'd0);
    @(negedge clk); rstN = 1;
    repeat (4) @(negedge clk);
    check("R11 flash zero", 64'(flashMask), 64'h00);
    busRead(1, A_UADDR, v); check("R11 pointer kept", 64'(v), 64'h03);
    busRead(1, aRow(0), v); check("R11 glyph kept", 64'(v), 64'h0A);
    refIdx = 4'd5; refRow = 3'd6;
    #1 check("R11 other glyph kept", 64'(refDots), 64'h10);
  endtask

  initial begin
    testReset();
    testChars();
    testFlash();
    testUdc();
    testControl();
    testStrobes();
    testClear();
    testResetKeeps();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule